// File: doc/BRIEF.md
# SIMD Byte Extract Unit

This unit executes a vector byte-extract operation. It receives one 32-bit instruction word, in either the fixed-width form or the two-halfword stream form, along with two source vectors. It decodes the register numbers, the 4-bit byte offset and the width bit. It then places the second source above the first and cuts out a window that begins at the selected byte. The window is 8 bytes wide in doubleword mode and 16 bytes wide in quadword mode. Every element is an untyped byte.

The surrounding pipeline reads the register file and passes in the two operands. In return it gets the result, the index of the destination register and a pair of flags. One flag reports a legal operation and the other reports an encoding that must be rejected. Register-file access, condition evaluation and privilege checks all stay outside the unit. A parameter places an output register after the datapath. With the register, results appear one cycle after the request. Without it, the unit is purely combinational.

Top module: `bext_unit`

## Requirements
- R1: The destination number is {insn[22], insn[15:12]}. In doubleword mode dst_idx equals that number. In quadword mode dst_idx equals the number shifted right by one, so bit 4 is 0.
- R2: With enc_sel=0, a legal word needs insn[31:23]=9'b111100101. With enc_sel=1, it needs 9'b111011111. Both forms also need insn[21:20]=2'b11 and insn[4]=0. Any other word is flagged undefined.
- R3: When insn[6]=0 (doubleword) and insn[11]=1 (offset above 7), the word is flagged undefined.
- R4: When insn[6]=1 (quadword) and any of insn[12], insn[16] or insn[0] is 1 (an odd register number), the word is flagged undefined.
- R5: In doubleword mode, res[63:0] equals ({src_b[63:0], src_a[63:0]} >> 8*insn[11:8])[63:0], and res[127:64] is zero.
- R6: In quadword mode, res equals ({src_b, src_a} >> 8*insn[11:8])[127:0].
- R7: An offset of 0 returns src_a unchanged. The largest legal offset (7 or 15) returns the top byte of src_a in byte 0, with the lower bytes of src_b above it.
- R8: An undefined word with in_valid=1 gives res_undef=1, res_valid=0, res=0 and dst_idx=0. res_valid and res_undef are never both 1.
- R9: With REG_OUT=1, the outputs reflect the request one clock after it is presented. A cycle with in_valid=0 yields res_valid=0, res_undef=0, res=0 and dst_idx=0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Request present this cycle |
| enc_sel | input | 1 | 0 selects the fixed-width opcode form, 1 selects the halfword-stream form |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First source vector (lower half of the join) |
| src_b | input | 128 | Second source vector (upper half of the join) |
| res | output | 128 | Extracted window; upper 64 bits are zero in doubleword mode |
| dst_idx | output | 5 | Destination register index |
| res_valid | output | 1 | Legal operation completed |
| res_undef | output | 1 | Request carried an undefined encoding |

## Verification
On every cycle, the assertions check that the two flags are never set together, and that an output without res_valid carries a zero result and a zero index. They also check that doubleword results keep the upper half clear and that quadword indices have bit 4 clear. Against the request one cycle earlier, they check that an out-of-range doubleword offset and an odd quadword register are both rejected, and that an offset of zero passes src_a through. The byte positions of every window across all sixteen offsets, the exact opcode bit patterns of each encoding, and the register-number mapping can only be shown by the bench's sweeps against its own concatenate-and-shift model.

// File: rtl/bext_pkg.sv
package bext_pkg;

  localparam int REG_W = 5;
  localparam int IMM_W = 4;

  localparam logic [8:0] OPC_WIDE   = 9'b111100101;
  localparam logic [8:0] OPC_STREAM = 9'b111011111;

  typedef struct packed {
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
    logic [IMM_W-1:0] imm;
    logic             quad;
    logic             op_ok;
    logic             shape_ok;
  } bext_dec_t;

endpackage

// File: rtl/bext_decode.sv
module bext_decode
  import bext_pkg::*;
(
  input  logic        enc_sel,
  input  logic [31:0] insn,
  output bext_dec_t   dec,
  output logic        legal
);

  logic [8:0] want_top;

  always_comb begin
    want_top = enc_sel ? OPC_STREAM : OPC_WIDE;

    dec.rd   = {insn[22], insn[15:12]};
    dec.rn   = {insn[7],  insn[19:16]};
    dec.rm   = {insn[5],  insn[3:0]};
    dec.imm  = insn[11:8];
    dec.quad = insn[6];

    dec.op_ok = (insn[31:23] == want_top) && (insn[21:20] == 2'b11) && !insn[4];

    if (dec.quad) begin
      dec.shape_ok = !(dec.rd[0] | dec.rn[0] | dec.rm[0]);
    end else begin
      dec.shape_ok = !dec.imm[IMM_W-1];
    end

    legal = dec.op_ok && dec.shape_ok;
  end

endmodule

// File: rtl/bext_funnel.sv
module bext_funnel #(
  parameter int LANE_W = 128,
  parameter int BYTE_W = 8
) (
  input  logic [LANE_W-1:0]              src_lo,
  input  logic [LANE_W-1:0]              src_hi,
  input  logic [$clog2(LANE_W/BYTE_W)-1:0] imm,
  input  logic                           quad,
  output logic [LANE_W-1:0]              res
);

  localparam int NB    = LANE_W / BYTE_W;
  localparam int HB    = NB / 2;
  localparam int SEL_W = $clog2(2 * NB);
  localparam int HALF  = LANE_W / 2;

  logic [2*LANE_W-1:0] cat;

  always_comb begin
    if (quad) begin
      cat = {src_hi, src_lo};
    end else begin
      cat = {{LANE_W{1'b0}}, src_hi[HALF-1:0], src_lo[HALF-1:0]};
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [SEL_W-1:0]  idx;
    logic [BYTE_W-1:0] pick;
    always_comb begin
      idx  = SEL_W'(k) + SEL_W'(imm);
      pick = cat[idx*BYTE_W +: BYTE_W];
    end
    if (k >= HB) begin : g_upper
      assign res[k*BYTE_W +: BYTE_W] = quad ? pick : '0;
    end else begin : g_lower
      assign res[k*BYTE_W +: BYTE_W] = pick;
    end
  end

endmodule

// File: rtl/bext_unit.sv
module bext_unit
  import bext_pkg::*;
#(
  parameter int LANE_W  = 128,
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              enc_sel,
  input  logic [31:0]       insn,
  input  logic [LANE_W-1:0] src_a,
  input  logic [LANE_W-1:0] src_b,
  output logic [LANE_W-1:0] res,
  output logic [REG_W-1:0]  dst_idx,
  output logic              res_valid,
  output logic              res_undef
);

  localparam int OFF_W = $clog2(LANE_W / BYTE_W);
  localparam int HALF  = LANE_W / 2;

  bext_dec_t         dec;
  logic              legal;
  logic [LANE_W-1:0] win;

  logic [LANE_W-1:0] res_nxt;
  logic [REG_W-1:0]  dst_nxt;
  logic              val_nxt;
  logic              und_nxt;
  logic              quad_nxt;
  logic              quad_o;

  bext_decode u_dec (
    .enc_sel (enc_sel),
    .insn    (insn),
    .dec     (dec),
    .legal   (legal)
  );

  bext_funnel #(.LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_fun (
    .src_lo (src_a),
    .src_hi (src_b),
    .imm    (OFF_W'(dec.imm)),
    .quad   (dec.quad),
    .res    (win)
  );

  always_comb begin
    val_nxt  = in_valid && legal;
    und_nxt  = in_valid && !legal;
    quad_nxt = val_nxt && dec.quad;
    res_nxt  = val_nxt ? win : '0;
    if (!val_nxt) begin
      dst_nxt = '0;
    end else if (dec.quad) begin
      dst_nxt = {1'b0, dec.rd[REG_W-1:1]};
    end else begin
      dst_nxt = dec.rd;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res       <= '0;
        dst_idx   <= '0;
        res_valid <= 1'b0;
        res_undef <= 1'b0;
        quad_o    <= 1'b0;
      end else begin
        res       <= res_nxt;
        dst_idx   <= dst_nxt;
        res_valid <= val_nxt;
        res_undef <= und_nxt;
        quad_o    <= quad_nxt;
      end
    end

    // R3: out-of-range doubleword offset rejected one cycle later
    a_r3_dbl_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !insn[6] && insn[11]) |=> res_undef);

    // R4: odd register numbers in quadword mode rejected
    a_r4_odd_quad: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && insn[6] && (insn[12] || insn[16] || insn[0])) |=> res_undef);

    // R9: an idle cycle leaves both flags low
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && !res_undef));

    // R7: zero offset in quadword mode passes the first source through
    a_r7_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && insn[6] && insn[11:8] == 4'd0) |=> (!res_valid || res == $past(src_a)));
  end else begin : g_comb
    assign res       = res_nxt;
    assign dst_idx   = dst_nxt;
    assign res_valid = val_nxt;
    assign res_undef = und_nxt;
    assign quad_o    = quad_nxt;
  end

  // R8: flags mutually exclusive
  a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_undef));

  // R8: without a valid result, data and index are zero
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res == '0 && dst_idx == '0));

  // R5: doubleword result keeps the upper half clear
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !quad_o) |-> (res[LANE_W-1:HALF] == '0));

  // R1: quadword index fits in four bits
  a_r1_quad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && quad_o) |-> !dst_idx[REG_W-1]);

endmodule

// File: tb/tb_bext_unit.sv
`timescale 1ns/1ps
module tb_bext_unit;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         enc_sel;
  logic [31:0]  insn;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic [127:0] res;
  logic [4:0]   dst_idx;
  logic         res_valid;
  logic         res_undef;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bext_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .enc_sel   (enc_sel),
    .insn      (insn),
    .src_a     (src_a),
    .src_b     (src_b),
    .res       (res),
    .dst_idx   (dst_idx),
    .res_valid (res_valid),
    .res_undef (res_undef)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic sel, input logic [4:0] d5,
                                     input logic [4:0] n5, input logic [4:0] m5,
                                     input logic [3:0] imm, input logic q);
    logic [8:0] top;
    top = sel ? 9'b111011111 : 9'b111100101;
    return {top, d5[4], 2'b11, n5[3:0], d5[3:0], imm, n5[4], q, m5[4], 1'b0, m5[3:0]};
  endfunction

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(seed * 29 + i * 53 + 7);
    return v;
  endfunction

  function automatic logic [127:0] model(input logic q, input logic [3:0] imm,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [255:0] j;
    logic [127:0] jd;
    if (q) begin
      j = {b, a} >> (8 * imm);
      return j[127:0];
    end
    jd = {b[63:0], a[63:0]} >> (8 * imm);
    return {64'd0, jd[63:0]};
  endfunction

  task automatic apply(input logic sel, input logic [31:0] w,
                       input logic [127:0] a, input logic [127:0] b, input logic v);
    @(negedge clk);
    in_valid = v;
    enc_sel  = sel;
    insn     = w;
    src_a    = a;
    src_b    = b;
    @(negedge clk);
  endtask

  task automatic expect_ok(input string tag, input logic q, input logic [3:0] imm,
                           input logic [4:0] d5, input logic [127:0] a, input logic [127:0] b);
    check({tag, " res"}, res, model(q, imm, a, b));
    check({tag, " valid"}, 128'(res_valid), 128'd1);
    check({tag, " undef"}, 128'(res_undef), 128'd0);
    check({tag, " R1 dst"}, 128'(dst_idx), q ? 128'(d5 >> 1) : 128'(d5));
  endtask

  task automatic expect_undef(input string tag);
    check({tag, " R8 res"}, res, 128'd0);
    check({tag, " R8 valid"}, 128'(res_valid), 128'd0);
    check({tag, " undef"}, 128'(res_undef), 128'd1);
    check({tag, " R8 dst"}, 128'(dst_idx), 128'd0);
  endtask

  task automatic t_reset();
    in_valid = 1'b0; enc_sel = 1'b0; insn = '0; src_a = '0; src_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset res", res, 128'd0);
    check("R9 reset flags", {126'd0, res_valid, res_undef}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sweep_dbl();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++) begin
        logic [127:0] a = pat(k + 3 * s);
        logic [127:0] b = pat(k + 100 + s);
        logic [4:0] d5 = 5'(k * 5 + s * 17);
        apply(s[0], mk(s[0], d5, 5'd3, 5'd9, 4'(k), 1'b0), a, b, 1'b1);
        expect_ok("R5 dbl", 1'b0, 4'(k), d5, a, b);
      end
  endtask

  task automatic t_sweep_quad();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 16; k++) begin
        logic [127:0] a = pat(k + 50 + s);
        logic [127:0] b = ~pat(k + 7 * s);
        logic [4:0] d5 = 5'((k * 6 + s * 16) & 30);
        apply(s[0], mk(s[0], d5, 5'd20, 5'd30, 4'(k), 1'b1), a, b, 1'b1);
        expect_ok("R6 quad", 1'b1, 4'(k), d5, a, b);
      end
  endtask

  task automatic t_edges();
    logic [127:0] a = 128'h0f0e0d0c0b0a09080706050403020100;
    logic [127:0] b = 128'h1f1e1d1c1b1a19181716151413121110;
    apply(1'b0, mk(1'b0, 5'd2, 5'd4, 5'd6, 4'd0, 1'b1), a, b, 1'b1);
    check("R7 quad imm0", res, a);
    apply(1'b0, mk(1'b0, 5'd1, 5'd4, 5'd6, 4'd0, 1'b0), a, b, 1'b1);
    check("R7 dbl imm0", res, {64'd0, a[63:0]});
    apply(1'b1, mk(1'b1, 5'd2, 5'd4, 5'd6, 4'd15, 1'b1), a, b, 1'b1);
    check("R7 quad imm15", res, {b[119:0], a[127:120]});
    apply(1'b1, mk(1'b1, 5'd31, 5'd4, 5'd6, 4'd7, 1'b0), a, b, 1'b1);
    check("R7 dbl imm7", res, {64'd0, b[55:0], a[63:56]});
    check("R1 dbl dst31", 128'(dst_idx), 128'd31);
  endtask

  task automatic t_undef_dbl();
    for (int k = 8; k < 16; k++) begin
      apply(k[0], mk(k[0], 5'd1, 5'd2, 5'd3, 4'(k), 1'b0), pat(k), pat(k + 1), 1'b1);
      expect_undef("R3 dbl imm");
    end
  endtask

  task automatic t_undef_odd();
    apply(1'b0, mk(1'b0, 5'd3, 5'd2, 5'd4, 4'd1, 1'b1), pat(1), pat(2), 1'b1);
    expect_undef("R4 odd rd");
    apply(1'b0, mk(1'b0, 5'd2, 5'd17, 5'd4, 4'd1, 1'b1), pat(1), pat(2), 1'b1);
    expect_undef("R4 odd rn");
    apply(1'b1, mk(1'b1, 5'd2, 5'd2, 5'd5, 4'd1, 1'b1), pat(1), pat(2), 1'b1);
    expect_undef("R4 odd rm");
    apply(1'b0, mk(1'b0, 5'd2, 5'd16, 5'd20, 4'd1, 1'b1), pat(1), pat(2), 1'b1);
    expect_ok("R4 even ok", 1'b1, 4'd1, 5'd2, pat(1), pat(2));
  endtask

  task automatic t_opcode();
    logic [31:0] good;
    for (int s = 0; s < 2; s++) begin
      good = mk(s[0], 5'd4, 5'd6, 5'd8, 4'd2, 1'b0);
      for (int p = 20; p < 32; p++) begin
        if (p != 22) begin
          apply(s[0], good ^ (32'd1 << p), pat(p), pat(p + 9), 1'b1);
          expect_undef("R2 opcode bit");
        end
      end
      apply(s[0], good | 32'h10, pat(3), pat(4), 1'b1);
      expect_undef("R2 bit4");
      apply(~s[0], good, pat(3), pat(4), 1'b1);
      expect_undef("R2 wrong form");
    end
  endtask

  task automatic t_idle();
    apply(1'b0, mk(1'b0, 5'd4, 5'd6, 5'd8, 4'd2, 1'b0), pat(5), pat(6), 1'b0);
    check("R9 idle res", res, 128'd0);
    check("R9 idle flags", {126'd0, res_valid, res_undef}, 128'd0);
    check("R9 idle dst", 128'(dst_idx), 128'd0);
  endtask

  initial begin
    t_reset();
    t_sweep_dbl();
    t_sweep_quad();
    t_edges();
    t_undef_dbl();
    t_undef_odd();
    t_opcode();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule